// File: doc/BRIEF.md
# Register/Memory Move Instruction Length Decoder

This block receives an instruction byte stream, one byte per cycle under a valid/ready handshake. It recognises the register-from-memory move in its 8-bit form (opcode 0x8A) and its full-width form (opcode 0x8B). Two optional prefixes may come before the opcode: an operand-size prefix (0x66) and a 64-bit-width prefix (0x48). The byte after the opcode is a ModR/M byte. Its value alone sets how many displacement bytes follow, so the decoder collects a variable number of bytes for each instruction.

When the last byte of an instruction arrives, the decoder reports a one-cycle `done` pulse. With it come the total byte count, the destination register number, the operand size, the addressing mode, the base register and the displacement sign-extended to 32 bits. An encoding outside the supported subset ends the instruction early with `bad` set. In the cycle after `done`, the decoder is ready again for the first byte of the next instruction.

Top module: `movdec_top`

## Requirements
- R1: A byte is taken only when `in_valid` and `in_ready` are both high. `in_ready` is low only during the `done` cycle. The first byte of the next instruction is taken from the cycle after `done`.
- R2: `length` counts every byte taken for the instruction: prefixes, opcode, ModR/M and displacement. It ranges from 2 to 8 when the instruction is supported.
- R3: The ModR/M byte splits into mode (bits 7:6), register (bits 5:3) and r/m (bits 2:0). `dest_reg` equals the register field and `base_reg` equals the r/m field.
- R4: `addr_mode` is coded as 0 = indirect with no displacement (mode 00), 1 = base plus 8-bit displacement (mode 01), 2 = base plus 32-bit displacement (mode 10), 3 = register direct (mode 11).
- R5: An 8-bit displacement is sign-extended to 32 bits. A 32-bit displacement is assembled least significant byte first. `disp` is zero when no displacement byte is present.
- R6: Mode 00 with r/m 101 gives `addr_mode` 4. This is an absolute address taken from four displacement bytes, with no base register.
- R7: `op_size` is coded 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Opcode 0x8A always gives 0. Opcode 0x8B gives 2, or 1 after a 0x66 prefix, or 3 after a 0x48 prefix. The 0x48 prefix wins over 0x66.
- R8: A 0x48 byte in the prefix position while `long_mode` is low ends the instruction with `bad` high.
- R9: An r/m value of 100 with a mode other than 11 would need an extra index byte. It ends the instruction at the ModR/M byte with `bad` high.
- R10: Any of the following ends the instruction with `bad` high: a first-position byte that is neither a prefix nor 0x8A/0x8B, a repeated prefix, or 0x66 after 0x48.
- R11: `done` is high for exactly one cycle. It rises in the cycle after the final byte is taken. All result outputs stay unchanged until the next `done`.
- R12: On a `bad` ending, `length` counts the bytes taken, including the offending byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Instruction stream byte |
| long_mode | input | 1 | Permits the 64-bit-width prefix |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| bad | output | 1 | The finished instruction was not supported |
| length | output | 4 | Instruction length in bytes |
| dest_reg | output | 3 | Destination register number |
| op_size | output | 2 | Operand size code |
| addr_mode | output | 3 | Addressing mode code |
| base_reg | output | 3 | Base register number (r/m field) |
| disp | output | 32 | Sign-extended displacement |

## Verification
The bench builds the block with its default parameters: prefix codes 0x66 and 0x48, and the opcode pair 0x8A/0x8B. These values match the byte sequences a real instruction stream contains. The bench can therefore feed known encodings and compare the results with values worked out by hand: a negative 8-bit displacement, a little-endian 32-bit offset, an absolute address, a 16-bit and a 64-bit override, and a register-direct form. The same defaults also cover the rejection paths, which are a gated wide prefix, an index-byte form, a foreign opcode and a doubled prefix. One back-to-back case offers the next byte during the `done` cycle, to check that it is held off for exactly one cycle.

// File: rtl/movdec_pkg.sv
package movdec_pkg;

  localparam int BYTE_W     = 8;
  localparam int DISP_W     = 32;
  localparam int DISP_BYTES = DISP_W / BYTE_W;
  localparam int LANE_W     = $clog2(DISP_BYTES);
  localparam int LEN_W      = 4;
  localparam int REG_W      = 3;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} opsize_e;

  typedef enum logic [2:0] {
    AM_IND = 3'd0,
    AM_D8  = 3'd1,
    AM_D32 = 3'd2,
    AM_REG = 3'd3,
    AM_ABS = 3'd4
  } amode_e;

  typedef enum logic [1:0] {ST_LEAD, ST_MODRM, ST_DISP, ST_DONE} dstate_e;

  typedef struct packed {
    logic [1:0]       md;
    logic [REG_W-1:0] rg;
    logic [REG_W-1:0] rm;
  } modrm_t;

  function automatic amode_e amode_of(input modrm_t m);
    case (m.md)
      2'b00:   return (m.rm == 3'b101) ? AM_ABS : AM_IND;
      2'b01:   return AM_D8;
      2'b10:   return AM_D32;
      default: return AM_REG;
    endcase
  endfunction

  function automatic logic [2:0] disp_len(input amode_e a);
    case (a)
      AM_D8:          return 3'd1;
      AM_D32, AM_ABS: return 3'd4;
      default:        return 3'd0;
    endcase
  endfunction

  function automatic logic sib_needed(input modrm_t m);
    return (m.rm == 3'b100) && (m.md != 2'b11);
  endfunction

  function automatic opsize_e pick_size(input logic wide, input logic osz, input logic w64);
    if (!wide)    return SZ_8;
    else if (w64) return SZ_64;
    else if (osz) return SZ_16;
    else          return SZ_32;
  endfunction

  function automatic logic [DISP_W-1:0] widen8(input logic [BYTE_W-1:0] b);
    return {{(DISP_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

endpackage

// File: rtl/movdec_modrm_class.sv
module movdec_modrm_class
  import movdec_pkg::*;
(
  input  logic [BYTE_W-1:0] mbyte,
  output logic [REG_W-1:0]  reg_f,
  output logic [REG_W-1:0]  rm_f,
  output logic [2:0]        amode,
  output logic [2:0]        disp_n,
  output logic              sib_bad
);
  modrm_t m;
  amode_e am;

  always_comb begin
    m       = modrm_t'(mbyte);
    am      = amode_of(m);
    reg_f   = m.rg;
    rm_f    = m.rm;
    amode   = am;
    disp_n  = disp_len(am);
    sib_bad = sib_needed(m);
  end
endmodule

// File: rtl/movdec_disp_acc.sv
module movdec_disp_acc
  import movdec_pkg::*;
#(
  parameter int LANES = DISP_BYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    load,
  input  logic [LANE_W-1:0]       lane,
  input  logic [BYTE_W-1:0]       din,
  output logic [BYTE_W*LANES-1:0] word_next
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] nx;
    always_comb begin
      if (load && lane == LANE_W'(g)) nx = din;
      else if (clear)                 nx = '0;
      else                            nx = q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nx;
    end
    assign word_next[g*BYTE_W +: BYTE_W] = nx;
  end
endmodule

// File: rtl/movdec_ctrl.sv
module movdec_ctrl
  import movdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_OSZ  = 8'h66,
  parameter logic [BYTE_W-1:0] PFX_W64  = 8'h48,
  parameter logic [BYTE_W-1:0] OPC_PAIR = 8'h8A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              long_mode,
  input  logic [2:0]        disp_n,
  input  logic              sib_bad,
  output logic              in_ready,
  output logic              lead_phase,
  output logic              modrm_phase,
  output logic              disp_phase,
  output logic              done,
  output logic              fin_ok,
  output logic              fin_bad,
  output logic [LEN_W-1:0]  len_next,
  output logic [LANE_W-1:0] lane,
  output logic              wide,
  output logic              osz,
  output logic              w64
);
  dstate_e           st_q, st_d;
  logic [LEN_W-1:0]  len_q;
  logic [LANE_W-1:0] left_q, left_d, lane_q, lane_d;
  logic              wide_q, wide_d, osz_q, osz_d, w64_q, w64_d;
  logic              take;

  assign in_ready    = (st_q != ST_DONE);
  assign done        = (st_q == ST_DONE);
  assign lead_phase  = (st_q == ST_LEAD);
  assign modrm_phase = (st_q == ST_MODRM);
  assign disp_phase  = (st_q == ST_DISP);
  assign take        = in_valid && in_ready;
  assign lane        = lane_q;
  assign wide        = wide_q;
  assign osz         = osz_q;
  assign w64         = w64_q;

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    lane_d  = lane_q;
    wide_d  = wide_q;
    osz_d   = osz_q;
    w64_d   = w64_q;
    fin_ok  = 1'b0;
    fin_bad = 1'b0;
    len_next = take ? len_q + LEN_W'(1) : len_q;
    case (st_q)
      ST_LEAD: if (take) begin
        if (in_byte == PFX_OSZ) begin
          if (osz_q || w64_q) fin_bad = 1'b1;
          else                osz_d   = 1'b1;
        end else if (in_byte == PFX_W64) begin
          if (w64_q || !long_mode) fin_bad = 1'b1;
          else                     w64_d   = 1'b1;
        end else if (in_byte[BYTE_W-1:1] == OPC_PAIR[BYTE_W-1:1]) begin
          wide_d = in_byte[0];
          st_d   = ST_MODRM;
        end else begin
          fin_bad = 1'b1;
        end
      end
      ST_MODRM: if (take) begin
        if (sib_bad)           fin_bad = 1'b1;
        else if (disp_n == 3'd0) fin_ok = 1'b1;
        else begin
          st_d   = ST_DISP;
          left_d = LANE_W'(disp_n - 3'd1);
          lane_d = '0;
        end
      end
      ST_DISP: if (take) begin
        if (left_q == '0) fin_ok = 1'b1;
        else begin
          left_d = left_q - LANE_W'(1);
          lane_d = lane_q + LANE_W'(1);
        end
      end
      default: begin
        st_d   = ST_LEAD;
        wide_d = 1'b0;
        osz_d  = 1'b0;
        w64_d  = 1'b0;
        lane_d = '0;
        left_d = '0;
      end
    endcase
    if (fin_ok || fin_bad) st_d = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LEAD;
      len_q  <= '0;
      left_q <= '0;
      lane_q <= '0;
      wide_q <= 1'b0;
      osz_q  <= 1'b0;
      w64_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      len_q  <= (st_q == ST_DONE) ? '0 : len_next;
      left_q <= left_d;
      lane_q <= lane_d;
      wide_q <= wide_d;
      osz_q  <= osz_d;
      w64_q  <= w64_d;
    end
  end
endmodule

// File: rtl/movdec_top.sv
module movdec_top
  import movdec_pkg::*;
#(
  parameter logic [7:0] PFX_OSZ  = 8'h66,
  parameter logic [7:0] PFX_W64  = 8'h48,
  parameter logic [7:0] OPC_PAIR = 8'h8A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        long_mode,
  output logic        in_ready,
  output logic        done,
  output logic        bad,
  output logic [3:0]  length,
  output logic [2:0]  dest_reg,
  output logic [1:0]  op_size,
  output logic [2:0]  addr_mode,
  output logic [2:0]  base_reg,
  output logic [31:0] disp
);
  logic              lead_phase, modrm_phase, disp_phase;
  logic              fin_ok, fin_bad, wide, osz, w64;
  logic [LEN_W-1:0]  len_next;
  logic [LANE_W-1:0] lane;
  logic [BYTE_W-1:0] modrm_q, modrm_view;
  logic [REG_W-1:0]  reg_f, rm_f;
  logic [2:0]        amode, disp_n;
  logic              sib_bad;
  logic [DISP_W-1:0] disp_word;
  logic              take_modrm, take_disp;
  logic [DISP_W-1:0] disp_final;

  assign take_modrm = modrm_phase && in_valid;
  assign take_disp  = disp_phase && in_valid;
  assign modrm_view = modrm_phase ? in_byte : modrm_q;

  movdec_ctrl #(.PFX_OSZ(PFX_OSZ), .PFX_W64(PFX_W64), .OPC_PAIR(OPC_PAIR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .long_mode(long_mode), .disp_n(disp_n), .sib_bad(sib_bad),
    .in_ready(in_ready), .lead_phase(lead_phase), .modrm_phase(modrm_phase),
    .disp_phase(disp_phase), .done(done), .fin_ok(fin_ok), .fin_bad(fin_bad),
    .len_next(len_next), .lane(lane), .wide(wide), .osz(osz), .w64(w64)
  );

  movdec_modrm_class u_class (
    .mbyte(modrm_view), .reg_f(reg_f), .rm_f(rm_f), .amode(amode),
    .disp_n(disp_n), .sib_bad(sib_bad)
  );

  movdec_disp_acc #(.LANES(DISP_BYTES)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(take_modrm), .load(take_disp),
    .lane(lane), .din(in_byte), .word_next(disp_word)
  );

  always_comb begin
    case (amode_e'(amode))
      AM_D8:          disp_final = widen8(disp_word[BYTE_W-1:0]);
      AM_D32, AM_ABS: disp_final = disp_word;
      default:        disp_final = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modrm_q <= '0;
    else if (take_modrm) modrm_q <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad       <= 1'b0;
      length    <= '0;
      dest_reg  <= '0;
      op_size   <= '0;
      addr_mode <= '0;
      base_reg  <= '0;
      disp      <= '0;
    end else if (fin_ok || fin_bad) begin
      bad    <= fin_bad;
      length <= len_next;
      if (fin_ok) begin
        dest_reg  <= reg_f;
        op_size   <= pick_size(wide, osz, w64);
        addr_mode <= amode;
        base_reg  <= rm_f;
        disp      <= disp_final;
      end else begin
        dest_reg  <= '0;
        op_size   <= '0;
        addr_mode <= '0;
        base_reg  <= '0;
        disp      <= '0;
      end
    end
  end
endmodule

// File: rtl/movdec_chk.sv
module movdec_chk #(
  parameter logic [7:0] PFX_W64 = 8'h48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_byte,
  input logic        long_mode,
  input logic        done,
  input logic        bad,
  input logic [3:0]  length,
  input logic [2:0]  addr_mode,
  input logic [31:0] disp,
  input logic        lead_phase,
  input logic        modrm_phase
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(length) && $stable(disp));
  // R8
  w64_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_phase && in_valid && in_ready && in_byte == PFX_W64 && !long_mode) |=> (done && bad));
  // R9
  sib_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modrm_phase && in_valid && in_ready && in_byte[2:0] == 3'b100 && in_byte[7:6] != 2'b11) |=> (done && bad));
  // R2
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad) |-> (length >= 4'd2 && length <= 4'd8));
  // R5
  no_disp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad && (addr_mode == 3'd0 || addr_mode == 3'd3)) |-> disp == 32'd0);
  // R6
  abs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad && addr_mode == 3'd4) |-> length >= 4'd6);
endmodule

bind movdec_top movdec_chk #(.PFX_W64(PFX_W64)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .long_mode(long_mode), .done(done), .bad(bad),
  .length(length), .addr_mode(addr_mode), .disp(disp),
  .lead_phase(lead_phase), .modrm_phase(modrm_phase)
);

// File: tb/movdec_top_test.sv
`timescale 1ns/1ps
module movdec_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic long_mode = 1'b0;
  logic in_ready, done, bad;
  logic [3:0] length;
  logic [2:0] dest_reg, addr_mode, base_reg;
  logic [1:0] op_size;
  logic [31:0] disp;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  movdec_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .long_mode(long_mode), .in_ready(in_ready), .done(done), .bad(bad),
    .length(length), .dest_reg(dest_reg), .op_size(op_size),
    .addr_mode(addr_mode), .base_reg(base_reg), .disp(disp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bytes are taken from the low end of seq first
  task automatic feed(input logic [63:0] seq, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < gap; k++) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = seq[8*i +: 8];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input int len, input int dst, input int sz,
                           input int md, input int base, input logic [31:0] dv);
    chk({tag, " R11 done"}, 32'(done), 32'd1);
    chk({tag, " R12 bad"}, 32'(bad), 32'd0);
    chk({tag, " R2 length"}, 32'(length), 32'(len));
    chk({tag, " R3 dest"}, 32'(dest_reg), 32'(dst));
    chk({tag, " R7 size"}, 32'(op_size), 32'(sz));
    chk({tag, " R4 mode"}, 32'(addr_mode), 32'(md));
    chk({tag, " R3 base"}, 32'(base_reg), 32'(base));
    chk({tag, " R5 disp"}, disp, dv);
  endtask

  task automatic expect_bad(input string tag, input int len);
    chk({tag, " R11 done"}, 32'(done), 32'd1);
    chk({tag, " R10 bad"}, 32'(bad), 32'd1);
    chk({tag, " R12 length"}, 32'(length), 32'(len));
  endtask

  task automatic t_reset;
    chk("R1 reset ready", 32'(in_ready), 32'd1);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R2 reset length", 32'(length), 32'd0);
  endtask

  task automatic t_disp8_neg;
    feed(64'h00F8_458B, 3, 0);
    expect_ok("disp8 negative", 3, 0, 2, 1, 5, 32'hFFFF_FFF8);
    @(negedge clk);
    chk("R11 pulse ends", 32'(done), 32'd0);
  endtask

  task automatic t_disp32;
    feed(64'h0000_0478_808B, 6, 0);
    expect_ok("disp32 LE", 6, 0, 2, 2, 0, 32'h0000_0478);
  endtask

  task automatic t_indirect;
    feed(64'h008B, 2, 0);
    expect_ok("indirect", 2, 0, 2, 0, 0, 32'd0);
  endtask

  task automatic t_byte_form;
    feed(64'h00F8_458A, 3, 0);
    expect_ok("R7 8-bit form", 3, 0, 0, 1, 5, 32'hFFFF_FFF8);
  endtask

  task automatic t_osz;
    feed(64'h104E_8B66, 4, 0);
    expect_ok("R7 16-bit prefix", 4, 1, 1, 1, 6, 32'h0000_0010);
  endtask

  task automatic t_abs64;
    long_mode = 1'b1;
    feed(64'h0011_2233_441D_8B48, 7, 0);
    expect_ok("R6 absolute 64-bit", 7, 3, 3, 4, 5, 32'h1122_3344);
    long_mode = 1'b0;
  endtask

  task automatic t_both_prefixes;
    long_mode = 1'b1;
    feed(64'hC18B_4866, 4, 0);
    expect_ok("R7 wide over 16", 4, 0, 3, 3, 1, 32'd0);
    long_mode = 1'b0;
  endtask

  task automatic t_w64_gated;
    feed(64'h48, 1, 0);
    expect_bad("R8 wide prefix gated", 1);
  endtask

  task automatic t_sib;
    feed(64'h048B, 2, 0);
    expect_bad("R9 index byte form", 2);
  endtask

  task automatic t_foreign;
    feed(64'h89, 1, 0);
    expect_bad("R10 foreign opcode", 1);
    feed(64'h6666, 2, 0);
    expect_bad("R10 doubled prefix", 2);
  endtask

  task automatic t_gaps_and_hold;
    feed(64'h8000_0100_858B, 6, 2);
    expect_ok("R1 gapped valid", 6, 0, 2, 2, 5, 32'h8000_0100);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk("R11 hold length", 32'(length), 32'd6);
    chk("R11 hold disp", disp, 32'h8000_0100);
    chk("R11 hold done low", 32'(done), 32'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); in_valid = 1'b1; in_byte = 8'h8B; @(posedge clk);
    @(negedge clk); in_byte = 8'h00; @(posedge clk);
    @(negedge clk);
    chk("R11 first done", 32'(done), 32'd1);
    in_byte = 8'h8B;
    chk("R1 stalled in done", 32'(in_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready after done", 32'(in_ready), 32'd1);
    chk("R1 no done", 32'(done), 32'd0);
    @(posedge clk);
    @(negedge clk); in_byte = 8'hC8; @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    expect_ok("R1 held byte taken once", 2, 1, 2, 3, 0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disp8_neg();
    t_disp32();
    t_indirect();
    t_byte_form();
    t_osz();
    t_abs64();
    t_both_prefixes();
    t_w64_gated();
    t_sib();
    t_foreign();
    t_gaps_and_hold();
    t_back_to_back();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule